// File: doc/BRIEF.md
# Arbitrated Dual-Port Memory

This block is a single-clock memory with one shared word array and two ports, A and B, that work in the same cycle without waiting on each other. Each port has its own address, write data, write enable and read data. A word written through either port can be read back through either port at a later clock edge.

Two same-cycle conflicts are resolved in a fixed way. When both ports write the same word on one edge, port A's data is stored, port B's write is dropped, and a one-cycle collision flag is raised. What a port's output shows while it writes is chosen at build time: the new data, the old contents, or the previous output held. A port that reads a word the other port is writing in the same cycle always gets the old contents. A second build option turns port B's read path into a combinational one, while port A stays registered.

Top module: `arb_dpram`

## Requirements
- R1: Both ports share one array. A word written through either port is returned by a later read of that address on either port.
- R2: With registered reads, a port's read data changes only on a rising clock edge. It shows the word at the address presented before that edge, one cycle after the address is applied.
- R3: When both ports write the same address on the same edge, the array keeps port A's data and port B's write is discarded.
- R4: `collide` is high for exactly the one cycle after an edge where both write enables were high with equal addresses. It is low otherwise.
- R5: A port that reads, without writing, an address the other port writes on the same edge returns the old contents. The new value appears on a later read.
- R6: With `RDW_MODE` = write-first (the default, encoding 0), a writing port's read data becomes its own write data after the edge.
- R7: With `RDW_MODE` = read-first (encoding 1), a writing port's read data becomes the contents that the address held before the write.
- R8: With `RDW_MODE` = no-change (encoding 2), a writing port's read data keeps its previous value.
- R9: In write-first mode, a port B write that loses a collision shows port A's data, the value actually stored.
- R10: The array holds zeros at start-up. The synchronous active-high reset clears both registered read outputs and `collide`.
- R11: With `B_ASYNC_READ` = 1, port B's read data follows the array contents at `b_addr` combinationally, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst | input | 1 | Synchronous active-high reset of the outputs |
| a_we | input | 1 | Port A write enable |
| a_addr | input | AW | Port A word address |
| a_wdata | input | WIDTH | Port A write data |
| a_rdata | output | WIDTH | Port A read data |
| b_we | input | 1 | Port B write enable |
| b_addr | input | AW | Port B word address |
| b_wdata | input | WIDTH | Port B write data |
| b_rdata | output | WIDTH | Port B read data |
| collide | output | 1 | One-cycle same-address double-write flag |

## Verification
Four instances, one per read-during-write mode plus one with combinational port B reads, receive the same input sequence, and every output is compared with a reference array model every cycle. Directed steps cover the cases that tell the rules apart:
- a write read back through the other port, which separates a shared array from per-port storage;
- a cross-port read of a word being written, which separates old-data from new-data forwarding;
- a same-address double write, which shows which port wins and when the flag rises.

Random traffic is biased toward three addresses so that collisions and read-during-write overlaps happen often. Mode differences show only when a port writes, and this traffic exercises those cycles many times.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

    typedef enum logic [1:0] {
        RDW_WRITE_FIRST = 2'd0,
        RDW_READ_FIRST  = 2'd1,
        RDW_NO_CHANGE   = 2'd2
    } rdw_mode_e;

    function automatic int addr_bits(input int depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

endpackage

// File: rtl/dpram_collide.sv
module dpram_collide #(
    parameter int WIDTH = 8,
    parameter int AW    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             a_we,
    input  logic [AW-1:0]    a_addr,
    input  logic [WIDTH-1:0] a_wdata,
    input  logic             b_we,
    input  logic [AW-1:0]    b_addr,
    input  logic [WIDTH-1:0] b_wdata,
    output logic             b_commit,
    output logic [WIDTH-1:0] b_newword,
    output logic             flag_q
);
    logic hit;

    assign hit       = a_we && b_we && (a_addr == b_addr);
    assign b_commit  = b_we && !hit;
    assign b_newword = hit ? a_wdata : b_wdata;

    always_ff @(posedge clk) begin
        if (rst) flag_q <= 1'b0;
        else     flag_q <= hit;
    end
endmodule

// File: rtl/dpram_array.sv
module dpram_array #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16,
    parameter int AW    = 4
) (
    input  logic             clk,
    input  logic             a_we,
    input  logic [AW-1:0]    a_addr,
    input  logic [WIDTH-1:0] a_wdata,
    input  logic             b_commit,
    input  logic [AW-1:0]    b_addr,
    input  logic [WIDTH-1:0] b_wdata,
    output logic [WIDTH-1:0] a_word,
    output logic [WIDTH-1:0] b_word
);
    logic [WIDTH-1:0] store [DEPTH];

    initial begin
        for (int i = 0; i < DEPTH; i++) store[i] = '0;
    end

    // Port B is already gated off on a same-address clash, so A always wins.
    always_ff @(posedge clk) begin
        if (a_we)     store[a_addr] <= a_wdata;
        if (b_commit) store[b_addr] <= b_wdata;
    end

    assign a_word = store[a_addr];
    assign b_word = store[b_addr];
endmodule

// File: rtl/dpram_rdport.sv
module dpram_rdport
    import dpram_pkg::*;
#(
    parameter int        WIDTH = 8,
    parameter rdw_mode_e MODE  = RDW_WRITE_FIRST,
    parameter bit        ASYNC = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [WIDTH-1:0] newword,
    input  logic [WIDTH-1:0] oldword,
    output logic [WIDTH-1:0] rdata
);
    generate
        if (ASYNC) begin : g_comb
            logic unused_sync_inputs;
            assign unused_sync_inputs = ^{clk, rst, we, newword};
            assign rdata = oldword;
        end else begin : g_reg
            logic [WIDTH-1:0] q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    q <= '0;
                end else if (we) begin
                    case (MODE)
                        RDW_WRITE_FIRST: q <= newword;
                        RDW_READ_FIRST:  q <= oldword;
                        default:         q <= q;
                    endcase
                end else begin
                    q <= oldword;
                end
            end
            assign rdata = q;
        end
    endgenerate
endmodule

// File: rtl/arb_dpram.sv
module arb_dpram
    import dpram_pkg::*;
#(
    parameter int        WIDTH        = 8,
    parameter int        DEPTH        = 16,
    parameter rdw_mode_e RDW_MODE     = RDW_WRITE_FIRST,
    parameter bit        B_ASYNC_READ = 1'b0,
    localparam int       AW           = addr_bits(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             a_we,
    input  logic [AW-1:0]    a_addr,
    input  logic [WIDTH-1:0] a_wdata,
    output logic [WIDTH-1:0] a_rdata,
    input  logic             b_we,
    input  logic [AW-1:0]    b_addr,
    input  logic [WIDTH-1:0] b_wdata,
    output logic [WIDTH-1:0] b_rdata,
    output logic             collide
);
    logic             b_commit;
    logic [WIDTH-1:0] b_newword;
    logic [WIDTH-1:0] a_word;
    logic [WIDTH-1:0] b_word;

    dpram_collide #(.WIDTH(WIDTH), .AW(AW)) u_collide (
        .clk(clk), .rst(rst),
        .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata),
        .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata),
        .b_commit(b_commit), .b_newword(b_newword), .flag_q(collide)
    );

    dpram_array #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) u_array (
        .clk(clk),
        .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata),
        .b_commit(b_commit), .b_addr(b_addr), .b_wdata(b_wdata),
        .a_word(a_word), .b_word(b_word)
    );

    dpram_rdport #(.WIDTH(WIDTH), .MODE(RDW_MODE), .ASYNC(1'b0)) u_rd_a (
        .clk(clk), .rst(rst), .we(a_we),
        .newword(a_wdata), .oldword(a_word), .rdata(a_rdata)
    );

    dpram_rdport #(.WIDTH(WIDTH), .MODE(RDW_MODE), .ASYNC(B_ASYNC_READ)) u_rd_b (
        .clk(clk), .rst(rst), .we(b_we),
        .newword(b_newword), .oldword(b_word), .rdata(b_rdata)
    );
endmodule

// File: rtl/arb_dpram_chk.sv
module arb_dpram_chk
    import dpram_pkg::*;
#(
    parameter int        WIDTH   = 8,
    parameter int        AW      = 4,
    parameter rdw_mode_e MODE    = RDW_WRITE_FIRST,
    parameter bit        B_ASYNC = 1'b0
) (
    input logic             clk,
    input logic             rst,
    input logic             a_we,
    input logic [AW-1:0]    a_addr,
    input logic [WIDTH-1:0] a_wdata,
    input logic [WIDTH-1:0] a_rdata,
    input logic             b_we,
    input logic [AW-1:0]    b_addr,
    input logic [WIDTH-1:0] b_wdata,
    input logic [WIDTH-1:0] b_rdata,
    input logic             collide
);
    p_flag_set_r4: assert property (@(posedge clk) disable iff (rst)
        (a_we && b_we && a_addr == b_addr) |=> collide);

    p_flag_clear_r4: assert property (@(posedge clk) disable iff (rst)
        !(a_we && b_we && a_addr == b_addr) |=> !collide);

    p_reset_clears_r10: assert property (@(posedge clk)
        rst |=> (a_rdata == '0 && !collide));

    p_write_first_a_r6: assert property (@(posedge clk) disable iff (rst)
        (MODE == RDW_WRITE_FIRST && a_we) |=> a_rdata == $past(a_wdata));

    p_no_change_a_r8: assert property (@(posedge clk) disable iff (rst)
        (MODE == RDW_NO_CHANGE && a_we) |=> a_rdata == $past(a_rdata));

    p_loser_shows_winner_r9: assert property (@(posedge clk) disable iff (rst)
        (MODE == RDW_WRITE_FIRST && !B_ASYNC && a_we && b_we && a_addr == b_addr)
        |=> b_rdata == $past(a_wdata));

    p_b_write_unused: assert property (@(posedge clk) disable iff (rst)
        (MODE == RDW_WRITE_FIRST && !B_ASYNC && b_we && !(a_we && a_addr == b_addr))
        |=> b_rdata == $past(b_wdata));
endmodule

bind arb_dpram arb_dpram_chk #(
    .WIDTH(WIDTH), .AW(AW), .MODE(RDW_MODE), .B_ASYNC(B_ASYNC_READ)
) u_chk (
    .clk(clk), .rst(rst),
    .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
    .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata),
    .collide(collide)
);

// File: tb/arb_dpram_test.sv
module arb_dpram_test;
    import dpram_pkg::*;

    localparam int W = 8;
    localparam int D = 16;
    localparam int A = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic a_we = 1'b0, b_we = 1'b0;
    logic [A-1:0] a_addr = '0, b_addr = '0;
    logic [W-1:0] a_wdata = '0, b_wdata = '0;

    logic [W-1:0] wf_a, wf_b, rf_a, rf_b, nc_a, nc_b, as_a, as_b;
    logic wf_f, rf_f, nc_f, as_f;

    always #10 clk = ~clk;

    arb_dpram #(.WIDTH(W), .DEPTH(D), .RDW_MODE(RDW_WRITE_FIRST)) uut (
        .clk(clk), .rst(rst), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(wf_a),
        .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(wf_b), .collide(wf_f));
    arb_dpram #(.WIDTH(W), .DEPTH(D), .RDW_MODE(RDW_READ_FIRST)) uut_rf (
        .clk(clk), .rst(rst), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(rf_a),
        .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(rf_b), .collide(rf_f));
    arb_dpram #(.WIDTH(W), .DEPTH(D), .RDW_MODE(RDW_NO_CHANGE)) uut_nc (
        .clk(clk), .rst(rst), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(nc_a),
        .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(nc_b), .collide(nc_f));
    arb_dpram #(.WIDTH(W), .DEPTH(D), .RDW_MODE(RDW_WRITE_FIRST), .B_ASYNC_READ(1'b1)) uut_as (
        .clk(clk), .rst(rst), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(as_a),
        .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(as_b), .collide(as_f));

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [W-1:0] mdl [D];
    logic [W-1:0] ea_wf = '0, eb_wf = '0, ea_rf = '0, eb_rf = '0, ea_nc = '0, eb_nc = '0;
    logic eflag = 1'b0;

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [A-1:0] pick_addr();
        return ($urandom % 2 == 0) ? A'($urandom % 3) : A'($urandom % D);
    endfunction

    // Called just after a falling edge; checks outputs at the next falling edge.
    task automatic step(input logic wa, input logic [A-1:0] aa, input logic [W-1:0] da,
                        input logic wb, input logic [A-1:0] ab, input logic [W-1:0] db,
                        input string rtag);
        logic [W-1:0] oa, ob, nb;
        logic hit;
        a_we = wa; a_addr = aa; a_wdata = da;
        b_we = wb; b_addr = ab; b_wdata = db;
        #1;
        chk("R2", wf_a, ea_wf);
        chk("R2", wf_b, eb_wf);
        chk("R11", as_b, mdl[ab]);
        oa  = mdl[aa];
        ob  = mdl[ab];
        hit = wa && wb && (aa == ab);
        nb  = hit ? da : db;
        ea_wf = wa ? da : oa;
        eb_wf = wb ? nb : ob;
        ea_rf = oa;
        eb_rf = ob;
        ea_nc = wa ? ea_nc : oa;
        eb_nc = wb ? eb_nc : ob;
        eflag = hit;
        if (wa) mdl[aa] = da;
        if (wb && !hit) mdl[ab] = db;
        @(posedge clk);
        @(negedge clk);
        chk(wa ? "R6" : rtag, wf_a, ea_wf);
        chk(wb ? (hit ? "R9" : "R6") : rtag, wf_b, eb_wf);
        chk(wa ? "R7" : rtag, rf_a, ea_rf);
        chk(wb ? "R7" : rtag, rf_b, eb_rf);
        chk(wa ? "R8" : rtag, nc_a, ea_nc);
        chk(wb ? "R8" : rtag, nc_b, eb_nc);
        chk("R11", as_a, ea_wf);
        chk("R4", {7'b0, wf_f}, {7'b0, eflag});
        chk("R4", {7'b0, nc_f}, {7'b0, eflag});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < D; i++) mdl[i] = '0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset state of every output
        chk("R10", wf_a, '0); chk("R10", wf_b, '0);
        chk("R10", rf_a, '0); chk("R10", nc_b, '0);
        chk("R10", {7'b0, wf_f}, '0);
        rst = 1'b0;

        // R10: array starts at zero
        step(1'b0, 4'd3, 8'h00, 1'b0, 4'd12, 8'h00, "R10");
        // R5: B reads the word A is writing this cycle
        step(1'b1, 4'd5, 8'h5A, 1'b0, 4'd5, 8'h00, "R5");
        // R1: B sees A's data on a later read
        step(1'b0, 4'd0, 8'h00, 1'b0, 4'd5, 8'h00, "R1");
        // R1: A reads back a word written through B
        step(1'b0, 4'd9, 8'h00, 1'b1, 4'd9, 8'h33, "R5");
        step(1'b0, 4'd9, 8'h00, 1'b0, 4'd1, 8'h00, "R1");
        // R3: same-address double write, A wins
        step(1'b1, 4'd7, 8'h11, 1'b1, 4'd7, 8'h22, "R3");
        step(1'b0, 4'd7, 8'h00, 1'b0, 4'd7, 8'h00, "R3");
        // R8: back-to-back writes keep the held value in no-change mode
        step(1'b1, 4'd2, 8'hC3, 1'b1, 4'd4, 8'h3C, "R8");
        step(1'b1, 4'd2, 8'hC4, 1'b1, 4'd4, 8'h3D, "R8");
        step(1'b0, 4'd4, 8'h00, 1'b0, 4'd2, 8'h00, "R1");

        for (int n = 0; n < 600; n++) begin
            step($urandom % 2 == 0, pick_addr(), W'($urandom),
                 $urandom % 2 == 0, pick_addr(), W'($urandom), "R1");
        end

        // R10: reset after traffic clears outputs and flag
        a_we = 1'b0; b_we = 1'b0;
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R10", wf_a, '0); chk("R10", rf_b, '0);
        chk("R10", {7'b0, wf_f}, '0);
        finish_run();
    end
endmodule